// File: doc/BRIEF.md
# Host Serial Control and Readout Port

This block is the host-facing control port of a digital audio receiver. A host drives a three-wire synchronous link: a shift clock, a latch line and a data line. Data comes back on a return line that has a separate driver-enable output. Each transfer starts with an 8-bit address, shifted in LSB first while the latch is low. The latch then goes high. For a write, 8 command bits follow and take effect when the latch falls. For a read, the port shifts out a snapshot of one of two parallel buffers: the first 32 channel-status bits, or a flag followed by an 80-bit subcode record.

A framing pin chooses between two framings. Each framing has its own address set and its own return-line driver: open-drain or three-state. The command register is decoded into a system-stop bit, an input selector, a 2-bit auxiliary-output selector and a 2-bit audio-format code. The host lines are synchronised into the system clock domain, and every edge is detected there. The block does not capture the buffers; they arrive as parallel inputs from the demodulator.

Top module: `host_serial_port`

## Requirements
- R1: While reset is asserted, and after it is released, all command outputs are low and the return line is released (`hdo_oe_o` low, `hdo_o` high).
- R2: A write to 0xF7 with `framing_i` low, or to 0xEA with `framing_i` high, shifts 8 data bits in LSB first, one per rising shift-clock edge. The command register takes the new value on the falling latch edge that ends the transfer.
- R3: `stop_o` follows command bit 1 and `in_sel_o` follows command bit 2.
- R4: `aux_sel_o` is {bit 3, bit 4}. The codes are 0 = emphasis, 1 = validity flag, 2 = input-1 biphase, 3 = input-2 biphase.
- R5: `fmt_o` is {bit 5, bit 6}. The codes are 0 = 16-bit right-justified MSB first, 1 = 20-bit right-justified LSB first, 2 = 20-bit right-justified MSB first, 3 = 20-bit left-justified MSB first.
- R6: Command bits 0 and 7 have no effect on any output.
- R7: The command register is left unchanged, and the return line stays released, in these cases: an address outside the active framing's set, an address of the other framing, or an address phase that is not exactly 8 bits long.
- R8: A write whose data phase is not exactly 8 bits long leaves the command register unchanged.
- R9: Channel-status reads use 0xF8 (framing low) or 0xE9 (framing high). They return `cs_bits_i` LSB first, one bit per rising shift-clock edge. In framing high a constant-1 flag bit comes first; framing low sends no flag.
- R10: Subcode reads use 0xF9 (framing low) or 0xE8 (framing high). They return `sq_flag_i` first, then `sq_bits_i` from bit 0 upward.
- R11: During a read, `hdo_o` carries the current bit. In framing low `hdo_oe_o` is high only while that bit is 0 (open-drain). In framing high `hdo_oe_o` is high for the whole read (three-state).
- R12: The read buffer is sampled on the rising latch edge. Later changes on the buffer inputs do not alter the bits being shifted out.
- R13: After the falling latch edge that ends a read, the return line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| framing_i | input | 1 | Framing select: 0 = open-drain framing, 1 = three-state framing |
| hclk_i | input | 1 | Host shift clock |
| hle_i | input | 1 | Host latch: low = address phase, high = data phase |
| hdi_i | input | 1 | Host serial data in |
| cs_bits_i | input | 32 | Channel-status buffer |
| sq_flag_i | input | 1 | Subcode CRC-pass flag |
| sq_bits_i | input | 80 | Subcode record |
| hdo_o | output | 1 | Serial data out |
| hdo_oe_o | output | 1 | Driver enable for the data-out line |
| stop_o | output | 1 | System stop |
| in_sel_o | output | 1 | Demodulation input select |
| aux_sel_o | output | 2 | Auxiliary output select |
| fmt_o | output | 2 | Audio data format code |

## Verification
The bench targets these corner cases:
- **Bit mapping.** Swapping the two auxiliary-select bits, or the two format bits, would give the wrong code for asymmetric patterns. Letting command bits 0 or 7 leak into a field would change an output on a write of 0x81.
- **Cross-framing and malformed transfers.** An address from the other framing, and addresses or data phases of 7 or 9 bits, must be ignored. A design that latched on any latch fall would overwrite the command register.
- **Read framing.** A missing or misplaced flag would shift the whole bit stream by one. A buffer that is not snapshotted would show bits that were flipped in mid-read.
- **Driver behaviour.** Confusing open-drain with three-state would assert the enable while a 1 is being sent, or drop it during a read.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_WRITE, OP_RD_CS, OP_RD_SQ} op_e;

  localparam logic [7:0] A1_WR = 8'hF7;
  localparam logic [7:0] A1_CS = 8'hF8;
  localparam logic [7:0] A1_SQ = 8'hF9;
  localparam logic [7:0] A2_WR = 8'hEA;
  localparam logic [7:0] A2_CS = 8'hE9;
  localparam logic [7:0] A2_SQ = 8'hE8;

  typedef struct packed {
    logic [1:0] fmt;
    logic [1:0] aux;
    logic       in_sel;
    logic       stop;
  } ctrl_t;

  function automatic op_e addr_op(input logic fr, input logic [7:0] a);
    op_e r;
    r = OP_NONE;
    if (!fr) begin
      case (a)
        A1_WR:   r = OP_WRITE;
        A1_CS:   r = OP_RD_CS;
        A1_SQ:   r = OP_RD_SQ;
        default: r = OP_NONE;
      endcase
    end else begin
      case (a)
        A2_WR:   r = OP_WRITE;
        A2_CS:   r = OP_RD_CS;
        A2_SQ:   r = OP_RD_SQ;
        default: r = OP_NONE;
      endcase
    end
    return r;
  endfunction

  function automatic ctrl_t cmd_decode(input logic [7:0] w);
    ctrl_t c;
    c.stop   = w[1];
    c.in_sel = w[2];
    c.aux    = {w[3], w[4]};
    c.fmt    = {w[5], w[6]};
    return c;
  endfunction
endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);
  for (genvar g = 0; g < STAGES; g++) begin : g_st
    logic [W-1:0] q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '0;
        else         q <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '0;
        else         q <= g_st[g-1].q;
    end
  end

  assign q_o = g_st[STAGES-1].q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q_prev_o <= '0;
    else         q_prev_o <= q_o;
endmodule

// File: rtl/hsp_shift_in.sv
module hsp_shift_in #(
  parameter int W   = 8,
  parameter int CNT = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clear_i,
  input  logic           sample_i,
  input  logic           bit_i,
  output logic [W-1:0]   word_o,
  output logic [CNT-1:0] count_o
);
  localparam logic [CNT-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      word_o  <= '0;
      count_o <= '0;
    end else if (clear_i) begin
      word_o  <= '0;
      count_o <= '0;
    end else if (sample_i) begin
      word_o <= {bit_i, word_o[W-1:1]};  // first bit ends in word_o[0]
      if (count_o != CNT_MAX) count_o <= count_o + 1'b1;
    end
endmodule

// File: rtl/hsp_readout.sv
module hsp_readout #(
  parameter int CS_W = 32,
  parameter int SQ_W = 80
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            sel_sq_i,
  input  logic            cs_flag_i,
  input  logic [CS_W-1:0] cs_i,
  input  logic            sq_flag_i,
  input  logic [SQ_W-1:0] sq_i,
  input  logic            shift_i,
  output logic            bit_o
);
  localparam int LEN = SQ_W + 1;

  logic [LEN-1:0] sr, ld_val;

  always_comb begin
    ld_val = '1;
    if (sel_sq_i)       ld_val = {sq_i, sq_flag_i};
    else if (cs_flag_i) ld_val[CS_W:0] = {cs_i, 1'b1};
    else                ld_val[CS_W-1:0] = cs_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      sr <= '1;
    else if (load_i)  sr <= ld_val;
    else if (shift_i) sr <= {1'b1, sr[LEN-1:1]};

  assign bit_o = sr[0];
endmodule

// File: rtl/host_serial_port.sv
module host_serial_port
  import hsp_pkg::*;
#(
  parameter int CS_W        = 32,
  parameter int SQ_W        = 80,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            framing_i,
  input  logic            hclk_i,
  input  logic            hle_i,
  input  logic            hdi_i,
  input  logic [CS_W-1:0] cs_bits_i,
  input  logic            sq_flag_i,
  input  logic [SQ_W-1:0] sq_bits_i,
  output logic            hdo_o,
  output logic            hdo_oe_o,
  output logic            stop_o,
  output logic            in_sel_o,
  output logic [1:0]      aux_sel_o,
  output logic [1:0]      fmt_o
);
  localparam int WORD_W = 8;
  localparam int CNT_W  = $clog2(WORD_W) + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [2:0] s_now, s_prev;
  logic       hclk_rise, le_rise, le_fall;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  cnt;
  op_e   op, addr_dec;
  ctrl_t ctrl;
  logic  read_active, rd_bit;

  hsp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     ({hdi_i, hle_i, hclk_i}),
    .q_o     (s_now),
    .q_prev_o(s_prev)
  );

  assign hclk_rise = s_now[0] & ~s_prev[0];
  assign le_rise   = s_now[1] & ~s_prev[1];
  assign le_fall   = ~s_now[1] & s_prev[1];

  hsp_shift_in #(.W(WORD_W), .CNT(CNT_W)) u_shift_in (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (le_rise | le_fall),
    .sample_i(hclk_rise),
    .bit_i   (s_now[2]),
    .word_o  (word),
    .count_o (cnt)
  );

  assign addr_dec = (cnt == FULL) ? addr_op(framing_i, word) : OP_NONE;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      op <= OP_NONE;
    else if (le_rise) op <= addr_dec;
    else if (le_fall) op <= OP_NONE;

  // commit only a complete byte at the closing latch edge
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ctrl <= '0;
    else if (le_fall && op == OP_WRITE && cnt == FULL) ctrl <= cmd_decode(word);

  assign read_active = (op == OP_RD_CS) || (op == OP_RD_SQ);

  hsp_readout #(.CS_W(CS_W), .SQ_W(SQ_W)) u_readout (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (le_rise),
    .sel_sq_i (addr_dec == OP_RD_SQ),
    .cs_flag_i(framing_i),
    .cs_i     (cs_bits_i),
    .sq_flag_i(sq_flag_i),
    .sq_i     (sq_bits_i),
    .shift_i  (hclk_rise & read_active),
    .bit_o    (rd_bit)
  );

  assign hdo_o    = read_active ? rd_bit : 1'b1;
  assign hdo_oe_o = read_active & (framing_i | ~rd_bit);

  assign stop_o    = ctrl.stop;
  assign in_sel_o  = ctrl.in_sel;
  assign aux_sel_o = ctrl.aux;
  assign fmt_o     = ctrl.fmt;
endmodule

// File: rtl/hsp_chk.sv
module hsp_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       framing_i,
  input logic       le_fall_i,
  input logic       read_i,
  input logic       hdo_o,
  input logic       hdo_oe_o,
  input logic       stop_o,
  input logic       in_sel_o,
  input logic [1:0] aux_sel_o,
  input logic [1:0] fmt_o
);
  always @(posedge clk_i)
    if (!rst_ni) begin
      // R1
      reset_clear_chk: assert ({stop_o, in_sel_o, aux_sel_o, fmt_o, hdo_oe_o} == 7'd0);
    end

  // R2
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !le_fall_i |=> $stable({stop_o, in_sel_o, aux_sel_o, fmt_o}));

  // R11
  open_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!framing_i && hdo_oe_o) |-> !hdo_o);

  // R11
  tristate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (framing_i && read_i) |-> hdo_oe_o);

  // R13
  released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !read_i |-> (!hdo_oe_o && hdo_o));
endmodule

bind host_serial_port hsp_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .framing_i(framing_i),
  .le_fall_i(le_fall),
  .read_i   (read_active),
  .hdo_o    (hdo_o),
  .hdo_oe_o (hdo_oe_o),
  .stop_o   (stop_o),
  .in_sel_o (in_sel_o),
  .aux_sel_o(aux_sel_o),
  .fmt_o    (fmt_o)
);

// File: tb/host_serial_port_bench.sv
module host_serial_port_bench;
  localparam int HP = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic framing = 1'b0, hclk = 1'b0, hle = 1'b0, hdi = 1'b0;
  logic [31:0] cs_bits = '0;
  logic        sq_flag = 1'b0;
  logic [79:0] sq_bits = '0;
  logic hdo, hdo_oe, stop, in_sel;
  logic [1:0] aux_sel, fmt;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  host_serial_port u_host_serial_port (
    .clk_i(clk), .rst_ni(rst_ni), .framing_i(framing),
    .hclk_i(hclk), .hle_i(hle), .hdi_i(hdi),
    .cs_bits_i(cs_bits), .sq_flag_i(sq_flag), .sq_bits_i(sq_bits),
    .hdo_o(hdo), .hdo_oe_o(hdo_oe), .stop_o(stop), .in_sel_o(in_sel),
    .aux_sel_o(aux_sel), .fmt_o(fmt)
  );

  // {fr, addr, data, nbits, update}
  localparam int NV = 15;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 8'hF7, 8'h02, 4'd8, 1'b1},  // R3 stop
    {1'b0, 8'hF7, 8'h04, 4'd8, 1'b1},  // R3 in_sel
    {1'b1, 8'hEA, 8'h08, 4'd8, 1'b1},  // R4 aux=2
    {1'b1, 8'hEA, 8'h10, 4'd8, 1'b1},  // R4 aux=1
    {1'b0, 8'hF7, 8'h18, 4'd8, 1'b1},  // R4 aux=3
    {1'b0, 8'hF7, 8'h20, 4'd8, 1'b1},  // R5 fmt=2
    {1'b1, 8'hEA, 8'h40, 4'd8, 1'b1},  // R5 fmt=1
    {1'b1, 8'hEA, 8'h7E, 4'd8, 1'b1},  // R2 all fields
    {1'b0, 8'hF7, 8'h81, 4'd8, 1'b1},  // R6 bits 0/7 only
    {1'b0, 8'hEA, 8'h7E, 4'd8, 1'b0},  // R7 other framing
    {1'b1, 8'hF7, 8'h7E, 4'd8, 1'b0},  // R7 other framing
    {1'b0, 8'h55, 8'h7E, 4'd8, 1'b0},  // R7 unknown
    {1'b0, 8'hF7, 8'h66, 4'd7, 1'b0},  // R8 short
    {1'b0, 8'hF7, 8'h66, 4'd9, 1'b0},  // R8 long
    {1'b1, 8'hEA, 8'h66, 4'd8, 1'b1}   // R2 framing high
  };

  function automatic logic [5:0] exp_ctrl(input logic [7:0] d);
    return {d[5], d[6], d[3], d[4], d[2], d[1]};
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic put_bit(input logic b);
    hdi = b;
    wait_n(HP);
    hclk = 1'b1;
    wait_n(HP);
    hclk = 1'b0;
  endtask

  task automatic send_addr(input logic [7:0] a, input int nb);
    hle = 1'b0;
    for (int i = 0; i < nb; i++) put_bit(a[i % 8]);
    wait_n(HP);
    hle = 1'b1;
    wait_n(HP);
  endtask

  task automatic write_xfer(input logic fr, input logic [7:0] a, input logic [7:0] d, input int nb);
    framing = fr;
    send_addr(a, 8);
    for (int i = 0; i < nb; i++) put_bit(d[i % 8]);
    wait_n(HP);
    hle = 1'b0;
    wait_n(HP);
  endtask

  task automatic read_xfer(input logic fr, input logic [7:0] a, input int n, input bit flip,
                           output logic [127:0] bits, output logic [127:0] oes);
    bits = '0;
    oes  = '0;
    framing = fr;
    send_addr(a, 8);
    for (int i = 0; i < n; i++) begin
      bits[i] = hdo;
      oes[i]  = hdo_oe;
      if (flip && i == 0) begin
        cs_bits = ~cs_bits;
        sq_bits = ~sq_bits;
        sq_flag = ~sq_flag;
      end
      put_bit(1'b0);
      wait_n(HP);
    end
    hle = 1'b0;
    wait_n(HP);
  endtask

  function automatic logic [5:0] act_ctrl();
    return {fmt, aux_sel, in_sel, stop};
  endfunction

  function automatic logic [127:0] mask(input int n);
    return (128'd1 << n) - 128'd1;
  endfunction

  initial begin
    logic [5:0] expc;
    logic [127:0] b, o, e;
    logic [31:0] cs0;
    logic [79:0] sq0;
    wait_n(4);
    // R1 during reset
    check("R1", 128'({act_ctrl(), hdo_oe, hdo}), 128'({6'd0, 1'b0, 1'b1}));
    rst_ni = 1'b1;
    wait_n(4);
    check("R1", 128'({act_ctrl(), hdo_oe, hdo}), 128'({6'd0, 1'b0, 1'b1}));

    expc = '0;
    for (int v = 0; v < NV; v++) begin
      write_xfer(VEC[v][21], VEC[v][20:13], VEC[v][12:5], int'(VEC[v][4:1]));
      if (VEC[v][0]) begin
        expc = exp_ctrl(VEC[v][12:5]);
        check("R2/R3/R4/R5/R6", 128'(act_ctrl()), 128'(expc));
      end else begin
        check("R7/R8", 128'(act_ctrl()), 128'(expc));
      end
    end

    // R7 short address phase with a valid write address
    framing = 1'b0;
    send_addr(8'hF7, 7);
    for (int i = 0; i < 8; i++) put_bit(1'b1);
    wait_n(HP); hle = 1'b0; wait_n(HP);
    check("R7", 128'(act_ctrl()), 128'(expc));

    cs_bits = 32'hA5C3_0F71;
    sq_flag = 1'b0;
    sq_bits = 80'h1234_5678_9ABC_DEF0_0F1E;

    // R9 framing low, no flag; R11 open-drain
    read_xfer(1'b0, 8'hF8, 32, 0, b, o);
    e = 128'(cs_bits);
    check("R9", b, e);
    check("R11", o, ~e & mask(32));
    check("R13", 128'({hdo_oe, hdo}), 128'(2'b01));

    // R9 framing high, flag first; R11 three-state
    read_xfer(1'b1, 8'hE9, 33, 0, b, o);
    e = 128'({cs_bits, 1'b1});
    check("R9", b, e);
    check("R11", o, mask(33));

    // R10 framing low
    read_xfer(1'b0, 8'hF9, 81, 0, b, o);
    e = 128'({sq_bits, sq_flag});
    check("R10", b, e);
    check("R11", o, ~e & mask(81));

    // R10 framing high, flag set; R12 inputs flipped after latch rise
    sq_flag = 1'b1;
    cs0 = cs_bits;
    sq0 = sq_bits;
    read_xfer(1'b1, 8'hE8, 81, 1, b, o);
    e = 128'({sq0, 1'b1});
    check("R10/R12", b, e);
    check("R11", o, mask(81));
    check("R13", 128'({hdo_oe, hdo}), 128'(2'b01));

    // R12 channel status snapshot
    cs_bits = cs0;
    read_xfer(1'b0, 8'hF8, 32, 1, b, o);
    check("R12", b, 128'(cs0));

    // R7 read address of other framing: line stays released
    read_xfer(1'b1, 8'hF8, 16, 0, b, o);
    check("R7", o, 128'd0);
    check("R7", b, mask(16));
    check("R7", 128'(act_ctrl()), 128'(expc));

    // R1 reset mid-operation
    write_xfer(1'b0, 8'hF7, 8'h7E, 8);
    check("R2", 128'(act_ctrl()), 128'(exp_ctrl(8'h7E)));
    rst_ni = 1'b0;
    wait_n(2);
    check("R1", 128'({act_ctrl(), hdo_oe}), 128'd0);
    rst_ni = 1'b1;
    wait_n(4);
    check("R1", 128'({act_ctrl(), hdo_oe}), 128'd0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule